// File: doc/BRIEF.md
# Accumulator ALU Datapath with Flags

An 8-bit arithmetic and logic datapath for a small accumulator processor. One operand comes from the shared data bus. The other comes from a private operand latch. The selected operation produces a pre-shift value, which then passes through a single-bit right shifter that can be switched off. The shifter output is the datapath result.

The result drives three things: the flag calculation, the write-back into the operand latch and the write-back into the accumulator. Each destination has its own write enable. The flags register holds carry, zero, sign and overflow. It can instead be loaded with the low four result bits, so that microcode can save the flags through the bus and restore them later.

Top module: `acc_alu_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the operand latch, the accumulator and the flags to zero at the next rising edge.
- R2: With `op_sel`=0 (add), the pre-shift value is (bus + latch) mod 256, and carry is the carry-out of the 8-bit addition.
- R3: With `op_sel`=1, the pre-shift value is bus minus latch. With `op_sel`=2, it is latch minus bus. Both are computed as minuend + inverted subtrahend + 1, so carry is 1 exactly when there is no borrow (minuend >= subtrahend, unsigned).
- R4: For the arithmetic codes 0 to 2 with the shifter off, overflow is set when the two effective addends share a sign bit and the result sign differs from it. This is the two's-complement overflow of the signed add or subtract.
- R5: Codes 3, 4 and 5 give bitwise XOR, OR and AND of bus and latch. With the shifter off, carry and overflow are 0.
- R6: Codes 6 and 7 pass the bus value unchanged as the pre-shift value. Carry and overflow are 0 with the shifter off, so code 6 with `shift_en`=1 yields bus >> 1.
- R7: With `shift_en`=1, the result is the pre-shift value shifted right by one with a 0 entering bit 7. Carry becomes bit 0 of the pre-shift value and overflow is 0. With `shift_en`=0, the result equals the pre-shift value.
- R8: Zero is set exactly when all 8 result bits are 0. Sign equals result bit 7.
- R9: On a rising edge, `wr_latch` loads the result into the latch and `wr_acc` loads it into the accumulator. The two are independent, and a register whose enable is low keeps its value.
- R10: When `wr_flags` is low, the flags register keeps its value whatever `raw_flags`, `op_sel` and the operands are. When `wr_flags` is high and `raw_flags` is low, it loads the computed flags.
- R11: When `wr_flags` and `raw_flags` are both high, the flags register loads result bits 3..0 and ignores bits 7..4. `flags_out` uses one layout for both raw and computed loads: bit 0 carry, bit 1 zero, bit 2 sign, bit 3 overflow. Driving `flags_out` onto the bus with code 6 and a raw load therefore restores the same flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 8 | Operand from the data bus |
| op_sel | input | 3 | Operation code (0 add, 1 bus-latch, 2 latch-bus, 3 xor, 4 or, 5 and, 6/7 pass bus) |
| shift_en | input | 1 | Enables the right shift by one |
| wr_latch | input | 1 | Loads the result into the operand latch |
| wr_acc | input | 1 | Loads the result into the accumulator |
| wr_flags | input | 1 | Loads the flags register |
| raw_flags | input | 1 | Selects result bits 3..0 as the flags source |
| result_out | output | 8 | Shifter output (combinational) |
| acc_out | output | 8 | Accumulator contents |
| flags_out | output | 4 | Flags: bit 0 carry, 1 zero, 2 sign, 3 overflow |

## Verification
The hardest cases to reach are the subtraction carry and overflow corners, because the second operand sits in the latch and cannot be driven directly. These corners are equal operands, 0x80 against 0x7F, and 0x00 against 0xFF. To reach them, the bench first loads each chosen latch value through the pass operation with only `wr_latch` set. It then sweeps every bus value over every code, with the shifter both off and on, and compares the result and the flags with signed and unsigned integer arithmetic. The latch values include 0x00, 0x7F, 0x80, 0x81 and 0xFF. Directed sequences also push a computed flags value back through the bus with a raw load, to show the round trip.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int unsigned FLAG_W = 4;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD      = 3'd0,
    OP_SUB      = 3'd1,
    OP_RSUB     = 3'd2,
    OP_XOR      = 3'd3,
    OP_OR       = 3'd4,
    OP_AND      = 3'd5,
    OP_PASS     = 3'd6,
    OP_PASS_ALT = 3'd7
  } alu_op_e;

  // bit 3 overflow, bit 2 sign, bit 1 zero, bit 0 carry
  typedef struct packed {
    logic v;
    logic s;
    logic z;
    logic c;
  } alu_flags_t;

  function automatic logic op_is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_RSUB);
  endfunction

  function automatic logic op_is_logic(alu_op_e op);
    return (op == OP_XOR) || (op == OP_OR) || (op == OP_AND);
  endfunction

endpackage

// File: rtl/acc_alu_reg.sv
module acc_alu_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] pre,
  output logic         carry,
  output logic         ovf,
  output logic         arith
);

  // returns {overflow, carry, sum}
  function automatic logic [W+1:0] add_ops(input logic [W-1:0] x,
                                           input logic [W-1:0] y,
                                           input logic         cin);
    logic [W:0] s;
    logic       v;
    s = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    v = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
    return {v, s};
  endfunction

  logic [W+1:0] sum_w;

  always_comb begin
    sum_w = '0;
    pre   = '0;
    case (op)
      OP_ADD:  sum_w = add_ops(a, b, 1'b0);
      OP_SUB:  sum_w = add_ops(a, ~b, 1'b1);
      OP_RSUB: sum_w = add_ops(b, ~a, 1'b1);
      OP_XOR:  pre = a ^ b;
      OP_OR:   pre = a | b;
      OP_AND:  pre = a & b;
      default: pre = a;
    endcase
    arith = op_is_arith(op);
    if (arith) pre = sum_w[W-1:0];
    carry = arith & sum_w[W];
    ovf   = arith & sum_w[W+1];
  end

endmodule

// File: rtl/acc_alu_shifter.sv
module acc_alu_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         out_bit
);

  for (genvar i = 0; i < W - 1; i++) begin : g_lane
    assign dout[i] = en ? din[i+1] : din[i];
  end
  assign dout[W-1] = en ? 1'b0 : din[W-1];
  assign out_bit   = din[0];

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         raw,
  input  logic         shift_en,
  input  logic         arith,
  input  logic [W-1:0] res,
  input  logic         pre_carry,
  input  logic         pre_ovf,
  input  logic         shift_bit,
  output alu_flags_t   flags_calc,
  output alu_flags_t   flags_q
);

  alu_flags_t          flags_next;
  logic [FLAG_W-1:0]   flags_bits;

  always_comb begin
    flags_calc.c = shift_en ? shift_bit : (arith & pre_carry);
    flags_calc.v = ~shift_en & arith & pre_ovf;
    flags_calc.z = ~|res;
    flags_calc.s = res[W-1];
    flags_next   = raw ? alu_flags_t'(res[FLAG_W-1:0]) : flags_calc;
  end

  acc_alu_reg #(.W(FLAG_W)) u_flag_reg (
    .clk (clk),
    .rst (rst),
    .en  (load),
    .d   (flags_next),
    .q   (flags_bits)
  );
  assign flags_q = alu_flags_t'(flags_bits);

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(flags_q));

  p_raw_load_r11: assert property (@(posedge clk) disable iff (rst)
    (load && raw) |=> (flags_q == $past(res[FLAG_W-1:0])));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (load && !raw) |=> (flags_q.z == ($past(res) == '0)) && (flags_q.s == $past(res[W-1])));

  p_shift_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (load && !raw && shift_en) |=> (flags_q.c == $past(shift_bit)) && !flags_q.v);

endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [2:0]        op_sel,
  input  logic              shift_en,
  input  logic              wr_latch,
  input  logic              wr_acc,
  input  logic              wr_flags,
  input  logic              raw_flags,
  output logic [DATA_W-1:0] result_out,
  output logic [DATA_W-1:0] acc_out,
  output logic [3:0]        flags_out
);

  localparam int unsigned MSB = DATA_W - 1;

  alu_op_e           op;
  logic [DATA_W-1:0] latch_q;
  logic [DATA_W-1:0] pre_val;
  logic              pre_carry;
  logic              pre_ovf;
  logic              is_arith;
  logic              shift_bit;
  alu_flags_t        flags_calc;
  alu_flags_t        flags_q;
  logic              rst_d;

  assign op = alu_op_e'(op_sel);

  acc_alu_core #(.W(DATA_W)) u_core (
    .op    (op),
    .a     (bus_in),
    .b     (latch_q),
    .pre   (pre_val),
    .carry (pre_carry),
    .ovf   (pre_ovf),
    .arith (is_arith)
  );

  acc_alu_shifter #(.W(DATA_W)) u_shift (
    .en      (shift_en),
    .din     (pre_val),
    .dout    (result_out),
    .out_bit (shift_bit)
  );

  acc_alu_flags #(.W(DATA_W)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .load       (wr_flags),
    .raw        (raw_flags),
    .shift_en   (shift_en),
    .arith      (is_arith),
    .res        (result_out),
    .pre_carry  (pre_carry),
    .pre_ovf    (pre_ovf),
    .shift_bit  (shift_bit),
    .flags_calc (flags_calc),
    .flags_q    (flags_q)
  );

  acc_alu_reg #(.W(DATA_W)) u_latch (
    .clk (clk), .rst (rst), .en (wr_latch), .d (result_out), .q (latch_q)
  );

  acc_alu_reg #(.W(DATA_W)) u_acc (
    .clk (clk), .rst (rst), .en (wr_acc), .d (result_out), .q (acc_out)
  );

  assign flags_out = flags_q;

  always_ff @(posedge clk) rst_d <= rst;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (acc_out == '0) && (latch_q == '0) && (flags_q == '0));

  p_acc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_acc |=> $stable(acc_out));

  p_acc_load_r9: assert property (@(posedge clk) disable iff (rst)
    wr_acc |=> (acc_out == $past(result_out)));

  p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_latch |=> $stable(latch_q));

  p_sub_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUB && !shift_en) |-> (flags_calc.c == (bus_in >= latch_q)));

  p_add_ovf_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADD && !shift_en) |->
      (flags_calc.v == ((bus_in[MSB] == latch_q[MSB]) && (result_out[MSB] != bus_in[MSB]))));

  p_logic_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (op_is_logic(op) && !shift_en) |-> (!flags_calc.c && !flags_calc.v));

  p_pass_bus_r6: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_PASS || op == OP_PASS_ALT) && !shift_en) |-> (result_out == bus_in));

endmodule

// File: tb/sim_acc_alu_datapath.sv
`timescale 1ns/1ps
module sim_acc_alu_datapath;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] bus_in;
  logic [2:0] op_sel;
  logic       shift_en, wr_latch, wr_acc, wr_flags, raw_flags;
  logic [7:0] result_out, acc_out;
  logic [3:0] flags_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  acc_alu_datapath u0 (
    .clk, .rst, .bus_in, .op_sel, .shift_en, .wr_latch, .wr_acc,
    .wr_flags, .raw_flags, .result_out, .acc_out, .flags_out
  );

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired act=%0d exp<=100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, let the next posedge act, sample 1ns later
  task automatic cyc(input int op, input int bus, input int sh,
                     input int wl, input int wa, input int wf, input int rf);
    @(negedge clk);
    op_sel = op[2:0]; bus_in = bus[7:0]; shift_en = sh[0];
    wr_latch = wl[0]; wr_acc = wa[0]; wr_flags = wf[0]; raw_flags = rf[0];
    @(posedge clk);
    #1;
  endtask

  // read the latch through the OR code with a zero bus, no writes
  task automatic read_latch(output int v);
    @(negedge clk);
    op_sel = 3'd4; bus_in = 8'h00; shift_en = 0;
    wr_latch = 0; wr_acc = 0; wr_flags = 0; raw_flags = 0;
    #1 v = int'(result_out);
  endtask

  function automatic int sgn(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // expected {flags, result}: flags bit0 c, bit1 z, bit2 s, bit3 v
  function automatic int model(input int op, input int a, input int b, input int sh);
    int t, st, c, v, r;
    c = 0; v = 0; t = 0; st = 0;
    case (op)
      0: begin t = a + b; c = (t > 255); st = sgn(a) + sgn(b); end
      1: begin t = a - b; c = (a >= b);  st = sgn(a) - sgn(b); end
      2: begin t = b - a; c = (b >= a);  st = sgn(b) - sgn(a); end
      3: t = a ^ b;
      4: t = a | b;
      5: t = a & b;
      default: t = a;
    endcase
    if (op <= 2) v = (st > 127 || st < -128);
    r = t & 255;
    if (sh != 0) begin c = r & 1; r = r >> 1; v = 0; end
    return ((v * 8 + ((r >> 7) & 1) * 4 + (r == 0 ? 2 : 0) + c) << 8) | r;
  endfunction

  function automatic int bsel(input int i);
    case (i)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h0F;
      4: return 8'h10;  5: return 8'h55;  6: return 8'h7E;  7: return 8'h7F;
      8: return 8'h80;  9: return 8'h81;  10: return 8'hAA; 11: return 8'hF0;
      12: return 8'hFE; default: return 8'hFF;
    endcase
  endfunction

  function automatic string rtag(input int op, input int sh);
    if (sh != 0) return "R7";
    case (op)
      0: return "R2";
      1, 2: return "R3";
      3, 4, 5: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    int lv, e, fsave;
    rst = 1; bus_in = 0; op_sel = 0; shift_en = 0;
    wr_latch = 0; wr_acc = 0; wr_flags = 0; raw_flags = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    #1;
    check("R1 acc after reset", int'(acc_out), 0);
    check("R1 flags after reset", int'(flags_out), 0);
    read_latch(lv); check("R1 latch after reset", lv, 0);

    // R9 independent write enables
    cyc(6, 8'h3C, 0, 0, 1, 0, 0);
    check("R9 acc only", int'(acc_out), 8'h3C);
    read_latch(lv); check("R9 latch untouched", lv, 0);
    cyc(6, 8'h5A, 0, 1, 0, 0, 0);
    check("R9 acc kept", int'(acc_out), 8'h3C);
    read_latch(lv); check("R9 latch only", lv, 8'h5A);
    cyc(7, 8'h81, 0, 1, 1, 0, 0);
    check("R9 both acc", int'(acc_out), 8'h81);
    read_latch(lv); check("R9 both latch", lv, 8'h81);
    cyc(0, 8'hFF, 0, 0, 0, 0, 0);
    check("R9 neither acc", int'(acc_out), 8'h81);
    read_latch(lv); check("R9 neither latch", lv, 8'h81);

    // R4/R11: 0x81+0x81 = 0x02, carry and overflow -> flags 0x9, then round trip
    cyc(0, 8'h81, 0, 0, 0, 1, 0);
    check("R4 add overflow flags", int'(flags_out), 4'h9);
    fsave = int'(flags_out);
    cyc(6, 8'hF0, 0, 0, 0, 0, 1);
    check("R10 hold with raw but no load", int'(flags_out), fsave);
    cyc(6, 8'h04, 0, 0, 0, 1, 1);
    check("R11 raw load 0x4", int'(flags_out), 4'h4);
    cyc(6, fsave, 0, 0, 0, 1, 1);
    check("R11 round trip", int'(flags_out), fsave);
    cyc(6, 8'hF6, 0, 0, 0, 1, 1);
    check("R11 upper bits ignored", int'(flags_out), 4'h6);
    cyc(6, 8'h16, 1, 0, 0, 1, 1);
    check("R11 raw after shift", int'(flags_out), 4'hB);
    cyc(1, 8'h00, 0, 0, 0, 0, 0);
    check("R10 hold without load", int'(flags_out), 4'hB);

    // R1 reset in mid run
    @(negedge clk) rst = 1;
    @(posedge clk); #1;
    @(negedge clk) rst = 0;
    #1;
    check("R1 acc after mid reset", int'(acc_out), 0);
    check("R1 flags after mid reset", int'(flags_out), 0);
    read_latch(lv); check("R1 latch after mid reset", lv, 0);

    // sweep: latch values x codes x shift x all bus values
    for (int bi = 0; bi < 14; bi++) begin
      int bv;
      bv = bsel(bi);
      cyc(6, bv, 0, 1, 0, 0, 0);
      for (int op = 0; op < 8; op++) begin
        for (int sh = 0; sh < 2; sh++) begin
          for (int a = 0; a < 256; a++) begin
            e = model(op, a, bv, sh);
            @(negedge clk);
            op_sel = op[2:0]; bus_in = a[7:0]; shift_en = sh[0];
            wr_latch = 0; wr_acc = 1; wr_flags = 1; raw_flags = 0;
            #1 check({rtag(op, sh), " result"}, int'(result_out), e & 255);
            @(posedge clk);
            #1;
            check("R8 R4 flags", int'(flags_out), e >> 8);
            check("R9 acc write", int'(acc_out), e & 255);
          end
        end
      end
      read_latch(lv); check("R9 latch stable in sweep", lv, bv);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule